// File: doc/BRIEF.md
# Ethernet transmit frame formatter

This block sits between a transmit packet buffer and the byte-wide side of a PHY. It takes packet bytes over a valid/ready stream and sends out the full MAC frame one byte per clock: a fixed start pattern, the packet itself, optional zero padding for short packets, and a four-byte frame check sequence. The check sequence is either generated internally or, when generation is off, taken from the packet's own last four bytes and verified.

Padding understands VLAN-tagged frames. Such frames get a longer minimum size. A frame counts as tagged either because its type field matches a programmed value, or because software has chosen to treat every frame as tagged. A programmable maximum length stops frames that grow too large. The rest of such a frame is read from the input and dropped. A huge-frame override lifts this limit.

Each frame ends with a one-cycle status pulse: completion (with an FCS error flag) or abort. Configuration is captured when a frame starts and stays fixed for that frame.

Top module: `eth_tx_framer`

## Requirements
- R1: Every frame on the output begins with seven bytes of 0x55 and then one byte of 0xD5. The packet bytes from the input follow in their original order.
- R2: With cfg_crc_en_i=1, four FCS bytes follow the last packet byte. The FCS is CRC-32 (reflected polynomial 0xEDB88320, preset all ones, result inverted), computed over every byte after 0xD5, and sent least significant byte first.
- R3: With cfg_crc_en_i=0 and cfg_pad_en_i=0, the input is forwarded unchanged, including its last four bytes. The last four bytes are checked as an FCS over the bytes before them. stat_fcs_err_o is 1 in the stat_done_o cycle if they are wrong, and 0 if they are right.
- R4: With cfg_pad_en_i=1, a packet of fewer than 60 bytes is followed by zero bytes until 60 data bytes have been sent, so the frame is 64 bytes including the FCS. Longer packets are not padded.
- R5: With cfg_pad_en_i=1, an FCS is generated and appended whatever cfg_crc_en_i is.
- R6: With cfg_pad_en_i=1, a frame is treated as VLAN in two cases: cfg_vlan_all_i=1, or cfg_vlan_auto_i=1 and packet bytes 12 (high) and 13 (low) equal cfg_vlan_type_i. A VLAN frame is padded to 64 data bytes (68 with FCS). Without cfg_pad_en_i these bits have no effect.
- R7: Frame length counts the bytes after 0xD5, including a generated FCS. If accepting a packet byte would push the frame length above cfg_max_len_i while cfg_huge_en_i=0, then four things happen. That byte is not sent. stat_abort_o pulses while out_valid_o is low. No stat_done_o follows. The rest of the packet is consumed without output, and the next packet is framed normally. With cfg_huge_en_i=1 there is no limit.
- R8: stat_done_o pulses for exactly the cycle of the last frame byte, which is marked by out_last_o.
- R9: After reset, out_valid_o, in_ready_o, out_last_o and all status outputs are 0.
- R10: A cycle with in_ready_o=1 and in_valid_i=0 produces a cycle with out_valid_o=0 one cycle later. No byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Packet byte |
| in_valid_i | input | 1 | Packet byte valid |
| in_last_i | input | 1 | Final byte of packet |
| in_ready_o | output | 1 | Byte accepted when high together with valid |
| out_data_o | output | 8 | Frame byte toward PHY |
| out_valid_o | output | 1 | Frame byte valid |
| out_last_o | output | 1 | Final frame byte |
| cfg_crc_en_i | input | 1 | Generate and append FCS |
| cfg_pad_en_i | input | 1 | Pad short frames, forces FCS generation |
| cfg_vlan_auto_i | input | 1 | Treat frames with matching type as VLAN |
| cfg_vlan_all_i | input | 1 | Treat every frame as VLAN |
| cfg_vlan_type_i | input | 16 | Type value that marks a VLAN frame |
| cfg_max_len_i | input | 16 | Maximum frame length in bytes |
| cfg_huge_en_i | input | 1 | Disable the length limit |
| stat_done_o | output | 1 | Frame completed pulse |
| stat_fcs_err_o | output | 1 | Supplied FCS wrong, valid with done |
| stat_abort_o | output | 1 | Frame aborted on length pulse |

## Verification
The bench covers several corner cases, each with the failure it would expose.

- A 14-byte-boundary type match, where the deciding byte arrives on the same cycle it is compared. Without a bypass of that byte, the frame would get the 60-byte pad target instead of 64.
- A frame whose length lands exactly on the limit, and one that goes one byte over. An off-by-one in the length compare would abort the first or pass the second. In generate mode the limit must also count the appended FCS.
- A frame with a corrupted supplied FCS, and one with a correct one. A wrong residue constant would flag both or neither.
- A frame that follows an aborted one. If the drain is missing, the leftover bytes would be framed as a new packet.
- Input gaps, which must show up as output gaps with no byte duplicated.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_DATA, ST_PAD, ST_FCS, ST_DRAIN
  } tx_state_e;

  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  function automatic logic [31:0] crc_byte(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o,
  output logic [31:0] crc_next_o
);
  import eth_tx_pkg::*;

  logic [31:0] crc_q;

  assign crc_next_o = crc_byte(crc_q, data_i);
  assign crc_o      = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '1;
    else if (clr_i) crc_q <= '1;
    else if (en_i)  crc_q <= crc_next_o;
  end
endmodule

// File: rtl/eth_tx_vlan_det.sv
module eth_tx_vlan_det #(
  parameter int LEN_W    = 16,
  parameter int TYPE_OFS = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [LEN_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  input  logic [15:0]      type_i,
  output logic             match_o
);
  localparam logic [LEN_W-1:0] HI_IDX = LEN_W'(TYPE_OFS);
  localparam logic [LEN_W-1:0] LO_IDX = LEN_W'(TYPE_OFS + 1);

  logic [7:0] hi_q;
  logic       match_q;
  logic       lo_hit;

  assign lo_hit  = en_i && (idx_i == LO_IDX) && ({hi_q, data_i} == type_i);
  // bypass so a packet ending on the low type byte still sees its match
  assign match_o = match_q | lo_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      match_q <= 1'b0;
    end else if (clr_i) begin
      match_q <= 1'b0;
    end else if (en_i) begin
      if (idx_i == HI_IDX) hi_q <= data_i;
      if (idx_i == LO_IDX) match_q <= lo_hit;
    end
  end
endmodule

// File: rtl/eth_tx_len_guard.sv
module eth_tx_len_guard #(
  parameter int LEN_W   = 16,
  parameter int FCS_LEN = 4
) (
  input  logic [LEN_W-1:0] count_i,
  input  logic             fcs_gen_i,
  input  logic [LEN_W-1:0] max_i,
  input  logic             huge_i,
  output logic             over_o
);
  localparam int EW = LEN_W + 2;

  logic [EW-1:0] need;

  assign need   = EW'(count_i) + EW'(1) + (fcs_gen_i ? EW'(FCS_LEN) : EW'(0));
  assign over_o = !huge_i && (need > EW'(max_i));
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int PRE_LEN    = 7,
  parameter int MIN_FRAME  = 64,
  parameter int VLAN_FRAME = 68,
  parameter int FCS_LEN    = 4,
  parameter int LEN_W      = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  in_data_i,
  input  logic        in_valid_i,
  input  logic        in_last_i,
  output logic        in_ready_o,
  output logic [7:0]  out_data_o,
  output logic        out_valid_o,
  output logic        out_last_o,
  input  logic        cfg_crc_en_i,
  input  logic        cfg_pad_en_i,
  input  logic        cfg_vlan_auto_i,
  input  logic        cfg_vlan_all_i,
  input  logic [15:0] cfg_vlan_type_i,
  input  logic [15:0] cfg_max_len_i,
  input  logic        cfg_huge_en_i,
  output logic        stat_done_o,
  output logic        stat_fcs_err_o,
  output logic        stat_abort_o
);
  import eth_tx_pkg::*;

  localparam int PRE_W = $clog2(PRE_LEN + 1);
  localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(PRE_LEN);
  localparam logic [LEN_W-1:0] MIN_DATA  = LEN_W'(MIN_FRAME - FCS_LEN);
  localparam logic [LEN_W-1:0] VLAN_DATA = LEN_W'(VLAN_FRAME - FCS_LEN);
  localparam int FI_W = $clog2(FCS_LEN);
  localparam logic [FI_W-1:0] FCS_LAST = FI_W'(FCS_LEN - 1);

  tx_state_e        state_q;
  logic [PRE_W-1:0] pre_cnt_q;
  logic [LEN_W-1:0] len_q, len_inc, pad_tgt;
  logic [FI_W-1:0]  fcs_idx_q;
  logic             gen_q, pad_q, vauto_q, vall_q;
  logic             accept, over, vlan_hit, is_vlan;
  logic             crc_en;
  logic [7:0]       crc_din;
  logic [31:0]      crc_cur, crc_nxt, fcs_word;
  logic [7:0]       dat_q;
  logic             vld_q, lst_q, done_q, err_q, abort_q;

  assign in_ready_o = (state_q == ST_DATA) || (state_q == ST_DRAIN);
  assign accept     = in_ready_o && in_valid_i;
  assign len_inc    = len_q + LEN_W'(1);
  assign is_vlan    = vall_q || (vauto_q && vlan_hit);
  assign pad_tgt    = is_vlan ? VLAN_DATA : MIN_DATA;
  assign crc_en     = (state_q == ST_PAD) || ((state_q == ST_DATA) && accept && !over);
  assign crc_din    = (state_q == ST_PAD) ? 8'h00 : in_data_i;
  assign fcs_word   = ~crc_cur;

  eth_tx_crc32 u_crc (
    .clk_i, .rst_ni,
    .clr_i      (state_q == ST_IDLE),
    .en_i       (crc_en),
    .data_i     (crc_din),
    .crc_o      (crc_cur),
    .crc_next_o (crc_nxt)
  );

  eth_tx_vlan_det #(.LEN_W(LEN_W)) u_vlan (
    .clk_i, .rst_ni,
    .clr_i   (state_q == ST_IDLE),
    .en_i    ((state_q == ST_DATA) && accept),
    .idx_i   (len_q),
    .data_i  (in_data_i),
    .type_i  (cfg_vlan_type_i),
    .match_o (vlan_hit)
  );

  eth_tx_len_guard #(.LEN_W(LEN_W), .FCS_LEN(FCS_LEN)) u_len (
    .count_i   (len_q),
    .fcs_gen_i (gen_q),
    .max_i     (LEN_W'(cfg_max_len_i)),
    .huge_i    (cfg_huge_en_i),
    .over_o    (over)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pre_cnt_q <= '0;
      len_q     <= '0;
      fcs_idx_q <= '0;
      gen_q     <= 1'b0;
      pad_q     <= 1'b0;
      vauto_q   <= 1'b0;
      vall_q    <= 1'b0;
      dat_q     <= '0;
      vld_q     <= 1'b0;
      lst_q     <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      vld_q   <= 1'b0;
      lst_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (in_valid_i) begin
          gen_q     <= cfg_crc_en_i | cfg_pad_en_i;
          pad_q     <= cfg_pad_en_i;
          vauto_q   <= cfg_vlan_auto_i;
          vall_q    <= cfg_vlan_all_i;
          pre_cnt_q <= '0;
          len_q     <= '0;
          state_q   <= ST_PRE;
        end
        ST_PRE: begin
          vld_q     <= 1'b1;
          dat_q     <= (pre_cnt_q == PRE_LAST) ? SFD_BYTE : PRE_BYTE;
          pre_cnt_q <= pre_cnt_q + PRE_W'(1);
          if (pre_cnt_q == PRE_LAST) state_q <= ST_DATA;
        end
        ST_DATA: if (accept) begin
          if (over) begin
            abort_q <= 1'b1;
            state_q <= in_last_i ? ST_IDLE : ST_DRAIN;
          end else begin
            vld_q <= 1'b1;
            dat_q <= in_data_i;
            len_q <= len_inc;
            if (in_last_i) begin
              fcs_idx_q <= '0;
              if (gen_q) begin
                state_q <= (pad_q && (len_inc < pad_tgt)) ? ST_PAD : ST_FCS;
              end else begin
                lst_q   <= 1'b1;
                done_q  <= 1'b1;
                err_q   <= (crc_nxt != CRC_RESIDUE);
                state_q <= ST_IDLE;
              end
            end
          end
        end
        ST_PAD: begin
          vld_q <= 1'b1;
          dat_q <= 8'h00;
          len_q <= len_inc;
          if (len_inc >= pad_tgt) state_q <= ST_FCS;
        end
        ST_FCS: begin
          vld_q     <= 1'b1;
          dat_q     <= fcs_word[{fcs_idx_q, 3'b000} +: 8];
          fcs_idx_q <= fcs_idx_q + FI_W'(1);
          if (fcs_idx_q == FCS_LAST) begin
            lst_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_DRAIN: if (accept && in_last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_data_o     = dat_q;
  assign out_valid_o    = vld_q;
  assign out_last_o     = lst_q;
  assign stat_done_o    = done_q;
  assign stat_fcs_err_o = err_q;
  assign stat_abort_o   = abort_q;
endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
  parameter int PRE_LEN = 7
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic [7:0] out_data_o,
  input logic       out_valid_o,
  input logic       out_last_o,
  input logic       stat_done_o,
  input logic       stat_fcs_err_o,
  input logic       stat_abort_o
);
  logic [15:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         pos_q <= '0;
    else if (out_last_o || stat_abort_o) pos_q <= '0;
    else if (out_valid_o && pos_q != 16'hFFFF) pos_q <= pos_q + 16'd1;
  end

  p_preamble_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && pos_q < 16'(PRE_LEN)) |-> out_data_o == 8'h55);

  p_sfd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && pos_q == 16'(PRE_LEN)) |-> out_data_o == 8'hD5);

  p_err_with_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_fcs_err_o |-> stat_done_o);

  p_abort_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_abort_o |-> (!out_valid_o && !stat_done_o));

  p_done_on_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_done_o |-> (out_last_o && out_valid_o));

  p_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> !out_valid_o);
endmodule

bind eth_tx_framer eth_tx_framer_chk #(.PRE_LEN(PRE_LEN)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_valid_i     (in_valid_i),
  .in_ready_o     (in_ready_o),
  .out_data_o     (out_data_o),
  .out_valid_o    (out_valid_o),
  .out_last_o     (out_last_o),
  .stat_done_o    (stat_done_o),
  .stat_fcs_err_o (stat_fcs_err_o),
  .stat_abort_o   (stat_abort_o)
);

// File: tb/eth_tx_framer_tb_top.sv
module eth_tx_framer_tb_top;
  typedef struct packed {
    logic [15:0] n;
    logic        crc;
    logic        pad;
    logic        vauto;
    logic        vall;
    logic [15:0] typ;
    logic [15:0] maxl;
    logic        huge;
    logic        bad;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'd20,  1'b1, 1'b0, 1'b0, 1'b0, 16'h0800, 16'd1518, 1'b0, 1'b0}, // crc only
    '{16'd20,  1'b0, 1'b1, 1'b0, 1'b0, 16'h0800, 16'd1518, 1'b0, 1'b0}, // pad forces fcs
    '{16'd20,  1'b0, 1'b1, 1'b1, 1'b0, 16'h8100, 16'd1518, 1'b0, 1'b0}, // auto vlan hit
    '{16'd20,  1'b1, 1'b1, 1'b1, 1'b0, 16'h0800, 16'd1518, 1'b0, 1'b0}, // auto vlan miss
    '{16'd20,  1'b0, 1'b1, 1'b0, 1'b1, 16'h0800, 16'd1518, 1'b0, 1'b0}, // all vlan
    '{16'd70,  1'b1, 1'b1, 1'b0, 1'b0, 16'h0800, 16'd1518, 1'b0, 1'b0}, // long, no pad
    '{16'd30,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 16'd1518, 1'b0, 1'b0}, // good supplied fcs
    '{16'd30,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 16'd1518, 1'b0, 1'b1}, // bad supplied fcs
    '{16'd100, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0800, 16'd64,   1'b0, 1'b0}, // abort + drain
    '{16'd100, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0800, 16'd64,   1'b1, 1'b0}, // huge override
    '{16'd64,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 16'd64,   1'b0, 1'b0}, // exact limit
    '{16'd65,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0800, 16'd64,   1'b0, 1'b0}, // one over
    '{16'd14,  1'b0, 1'b1, 1'b1, 1'b0, 16'h8100, 16'd1518, 1'b0, 1'b0}  // type at end
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid, out_last;
  logic        crc_en = 1'b0, pad_en = 1'b0, vauto = 1'b0, vall = 1'b0, huge = 1'b0;
  logic [15:0] vtype = 16'h8100, max_len = 16'd1518;
  logic        done, fcs_err, abort_p;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] in_buf [0:2047];
  logic [7:0] exp_buf[0:2047];
  logic [7:0] got    [0:2047];
  int in_n, exp_n, got_n;
  bit done_seen, err_seen, done_last, abort_seen, abort_vld;
  bit exp_done, exp_err, exp_abort;

  always #10 clk = ~clk;

  eth_tx_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_last_o(out_last),
    .cfg_crc_en_i(crc_en), .cfg_pad_en_i(pad_en), .cfg_vlan_auto_i(vauto),
    .cfg_vlan_all_i(vall), .cfg_vlan_type_i(vtype), .cfg_max_len_i(max_len),
    .cfg_huge_en_i(huge),
    .stat_done_o(done), .stat_fcs_err_o(fcs_err), .stat_abort_o(abort_p)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      got[got_n] = out_data;
      got_n++;
    end
    if (done) begin
      done_seen = 1; err_seen = fcs_err; done_last = out_last;
    end
    if (abort_p) begin
      abort_seen = 1; abort_vld = out_valid;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(int lo, int hi, bit from_exp);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = lo; k < hi; k++) begin
      logic [7:0] b = from_exp ? exp_buf[k] : in_buf[k];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ b[j];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  function automatic string tag_of(int v);
    case (v)
      0: return "R2";   1: return "R5";   2: return "R6";   3: return "R4";
      4: return "R6";   5: return "R4";   6: return "R3";   7: return "R3";
      8: return "R7";   9: return "R7";   10: return "R7";  11: return "R7";
      default: return "R6";
    endcase
  endfunction

  // builds input and expected frame from the requirements
  task automatic build(vec_t v, int idx);
    bit gen = v.crc | v.pad;
    int pl = gen ? int'(v.n) : int'(v.n) - 4;
    int k = -1;
    logic [31:0] f;
    for (int i = 0; i < pl; i++) in_buf[i] = 8'(i * 13 + idx * 29 + 1);
    if (pl > 13) begin in_buf[12] = v.typ[15:8]; in_buf[13] = v.typ[7:0]; end
    in_n = v.n;
    if (!gen) begin
      f = ref_crc(0, pl, 0);
      for (int j = 0; j < 4; j++) in_buf[pl + j] = f[8*j +: 8];
      if (v.bad) in_buf[pl + 3] ^= 8'h01;
    end
    for (int j = 0; j < 7; j++) exp_buf[j] = 8'h55;
    exp_buf[7] = 8'hD5;
    if (!v.huge)
      for (int i = 0; i < in_n; i++)
        if (k < 0 && (i + 1 + (gen ? 4 : 0)) > int'(v.maxl)) k = i;
    exp_done = 0; exp_err = 0; exp_abort = 0;
    if (k >= 0) begin
      for (int i = 0; i < k; i++) exp_buf[8 + i] = in_buf[i];
      exp_n = 8 + k; exp_abort = 1;
    end else if (!gen) begin
      for (int i = 0; i < in_n; i++) exp_buf[8 + i] = in_buf[i];
      exp_n = 8 + in_n; exp_done = 1; exp_err = v.bad;
    end else begin
      int d = in_n;
      bit vl = v.vall || (v.vauto && in_n >= 14 && {in_buf[12], in_buf[13]} == vtype);
      int tgt = vl ? 64 : 60;
      for (int i = 0; i < in_n; i++) exp_buf[8 + i] = in_buf[i];
      if (v.pad) while (d < tgt) begin exp_buf[8 + d] = 8'h00; d++; end
      f = ref_crc(8, 8 + d, 1);
      for (int j = 0; j < 4; j++) exp_buf[8 + d + j] = f[8*j +: 8];
      exp_n = 8 + d + 4; exp_done = 1;
    end
  endtask

  task automatic send(bit gap);
    int i = 0;
    @(posedge clk); #1;
    got_n = 0; done_seen = 0; err_seen = 0; done_last = 0; abort_seen = 0; abort_vld = 0;
    while (i < in_n) begin
      @(negedge clk);
      in_valid = 1; in_data = in_buf[i]; in_last = (i == in_n - 1);
      #1;
      if (in_ready) begin
        @(posedge clk);
        i++;
        if (gap && i < in_n) begin
          @(negedge clk); in_valid = 0; in_last = 0;
        end
      end
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    repeat (100) @(negedge clk);
  endtask

  task automatic compare(string tag);
    bit pre_ok = 1, body_ok = 1;
    int bad_at = -1;
    for (int i = 0; i < 8 && i < got_n; i++) if (got[i] != exp_buf[i]) pre_ok = 0;
    chk(pre_ok && got_n >= 8, "R1", "preamble/sfd", got_n, 8);
    chk(got_n == exp_n, tag, "frame length", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (body_ok && got[i] != exp_buf[i]) begin body_ok = 0; bad_at = i; end
    chk(body_ok, tag, "frame byte",
        bad_at < 0 ? 0 : int'(got[bad_at]), bad_at < 0 ? 0 : int'(exp_buf[bad_at]));
    chk(done_seen == exp_done && (!done_seen || done_last), "R8", "done on last",
        int'(done_seen), int'(exp_done));
    chk(err_seen == exp_err, "R3", "fcs error flag", int'(err_seen), int'(exp_err));
    chk(abort_seen == exp_abort && !abort_vld, "R7", "abort pulse",
        int'(abort_seen), int'(exp_abort));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !in_ready && !out_last && !done && !fcs_err && !abort_p,
        "R9", "reset outputs", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!out_valid && !in_ready, "R9", "idle after reset", int'(in_ready), 0);

    for (int v = 0; v < NV; v++) begin
      crc_en = VECS[v].crc; pad_en = VECS[v].pad; vauto = VECS[v].vauto;
      vall = VECS[v].vall; max_len = VECS[v].maxl; huge = VECS[v].huge;
      build(VECS[v], v);
      send(1'b0);
      compare(tag_of(v));
    end

    // R10: gaps on the input, padded frame
    crc_en = 0; pad_en = 1; vauto = 0; vall = 0; max_len = 16'd1518; huge = 0;
    build(VECS[1], 20);
    send(1'b1);
    compare("R10");

    // R6: vlan bits ignored without padding
    crc_en = 1; pad_en = 0; vauto = 0; vall = 1;
    build('{16'd20, 1'b1, 1'b0, 1'b0, 1'b1, 16'h8100, 16'd1518, 1'b0, 1'b0}, 21);
    send(1'b0);
    compare("R6");

    summary();
  end
endmodule